// File: doc/BRIEF.md
# Dual-Source Clock Output Divider

This block turns one of two timing sources into a divided, toggling output, once per output channel. The slow source runs at 32768 Hz and the fast source at roughly 4 MHz. Both reach the block as single-cycle tick strobes in the system clock domain. Each channel has its own 8-bit control byte. The byte enables the output, picks the source, and sets two division stages: a pre-divider that acts only on the fast source and a power-of-two post-divider.

The output is a register that inverts once every P x 2^n ticks of the chosen source. P is the pre-divider ratio, or 1 when the slow source is selected, and n is the post-divider exponent. Software writes a channel's byte through a small synchronous register port. Every write restarts that channel from a clean phase, so a new ratio takes effect at once.

Top module: `clkout_divider_bank`

## Requirements
- R1: While bit 0 (enable) of a channel's control byte is 0, that channel's output stays at 0 and incoming ticks have no effect on it.
- R2: Bit 4 selects the source: 0 selects the slow tick input and 1 selects the fast tick input. Ticks on the source that is not selected never change the output.
- R3: With the fast source selected, bits 7:5 select the pre-divider ratio. Codes 0 to 6 divide by 1, 2, 4, 8, 16, 32 and 64, and code 7 divides by 122.
- R4: With the slow source selected, the pre-divider code has no effect: the ratio is 1 whatever bits 7:5 hold.
- R5: Bits 3:1 hold an exponent n, and the post-divider divides the pre-divided tick stream by 2^n.
- R6: Each output inverts once per P x 2^n selected ticks. The output register changes at the same clock edge that samples the completing tick, so with both ratios at 1 it inverts on every selected tick.
- R7: A write to a channel's control byte clears that channel's counters and drives its output to 0 at that edge. Counting restarts from zero with the new settings.
- R8: Channels 0, 1 and 2 sit at addresses 0, 1 and 2 and run independently. The read port returns the addressed channel's stored byte. A write to an unused address changes no channel, and a read of an unused address returns 0.
- R9: After reset, all control bytes and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slow_tick | input | 1 | One-cycle strobe per 32768 Hz source period |
| fast_tick | input | 1 | One-cycle strobe per fast source period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Channel address for read and write |
| wdata | input | 8 | Control byte to write |
| rdata | output | 8 | Control byte of the addressed channel |
| clk_out | output | 3 | Divided output, one bit per channel |

## Verification
The bench builds the block with its defaults: three channels, a 2-bit address and a 3-bit post exponent. This makes the unused address 3 and the 122 pre-divider code reachable. It sweeps all eight pre-divider codes on the fast source and counts output inversions over windows of four full periods. It also combines code 7 with a nonzero exponent and checks that the slow source bypasses the pre-divider. Tests with only the unselected source ticking, a disabled channel and a rewrite in mid-count cover the cases where the output must stay quiet or restart.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CTRL_W     = 8;
  localparam int PRE_CODE_W = 3;
  localparam int POST_EXP_W = 3;
  localparam int PRE_CNT_W  = 7;
  localparam int PRE_TOP    = 122;

  // field order matters: software places each field at these bit positions
  typedef struct packed {
    logic [PRE_CODE_W-1:0] pre_code;  // bits 7:5
    logic                  src_fast;  // bit 4
    logic [POST_EXP_W-1:0] post_exp;  // bits 3:1
    logic                  enable;    // bit 0
  } ctrl_t;

  function automatic logic [PRE_CNT_W-1:0] pre_ratio(input logic [PRE_CODE_W-1:0] code);
    if (code == '1) pre_ratio = PRE_CNT_W'(PRE_TOP);
    else            pre_ratio = PRE_CNT_W'(1) << code;
  endfunction
endpackage

// File: rtl/clkdiv_prediv.sv
module clkdiv_prediv
  import clkdiv_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  tick_in,
  input  logic [PRE_CODE_W-1:0] code,
  output logic                  tick_out
);
  logic [PRE_CNT_W-1:0] cnt_q, cnt_d;
  logic [PRE_CNT_W-1:0] ratio;
  logic                 at_end;

  assign ratio    = pre_ratio(code);
  assign at_end   = (cnt_q == ratio - PRE_CNT_W'(1));
  assign tick_out = tick_in && at_end && !clr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (tick_in) cnt_d = at_end ? '0 : cnt_q + PRE_CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: phase counter never reaches the selected ratio
  a_r3_cnt_below_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio);
endmodule

// File: rtl/clkdiv_postdiv.sv
module clkdiv_postdiv
  import clkdiv_pkg::*;
#(
  parameter int EXP_W = POST_EXP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             tick_in,
  input  logic [EXP_W-1:0] exp_n,
  output logic             out_q
);
  localparam int CNT_W = (1 << EXP_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;
  logic             out_d;
  logic             wrap;

  assign limit = CNT_W'(({{CNT_W{1'b0}}, 1'b1} << exp_n) - 1'b1);
  assign wrap  = tick_in && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (clr || !en) begin
      cnt_d = '0;
      out_d = 1'b0;
    end else if (tick_in) begin
      cnt_d = wrap ? '0 : cnt_q + CNT_W'(1);
      if (wrap) out_d = !out_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  // R5: post counter stays within 2^n - 1
  a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);
endmodule

// File: rtl/clkdiv_channel.sv
module clkdiv_channel
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              fast_tick,
  input  logic              wr_hit,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              clk_out
);
  ctrl_t ctrl_q, ctrl_d;
  logic  sel_tick;
  logic  pre_tick;
  logic  pre_out;
  logic  clr;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_hit) ctrl_d = ctrl_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl_o   = ctrl_q;
  assign clr      = wr_hit || !ctrl_q.enable;
  assign sel_tick = ctrl_q.src_fast ? fast_tick : slow_tick;

  clkdiv_prediv u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .tick_in  (sel_tick && ctrl_q.src_fast),
    .code     (ctrl_q.pre_code),
    .tick_out (pre_out)
  );

  // slow source skips the pre-divider
  assign pre_tick = ctrl_q.src_fast ? pre_out : sel_tick;

  clkdiv_postdiv #(.EXP_W(POST_EXP_W)) u_post (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (wr_hit),
    .en      (ctrl_q.enable),
    .tick_in (pre_tick),
    .exp_n   (ctrl_q.post_exp),
    .out_q   (clk_out)
  );

  // R1: disabled channel output is low
  a_r1_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.enable |-> !clk_out);
  // R7: a write leaves the output low
  a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_hit) |-> !clk_out);
  // R2: output moves only after a selected tick or a write
  a_r2_change_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ((clk_out != $past(clk_out)) && !$past(wr_hit)) |-> $past(sel_tick));
endmodule

// File: rtl/clkout_divider_bank.sv
module clkout_divider_bank
  import clkdiv_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              fast_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] rdata,
  output logic [NUM_CH-1:0] clk_out
);
  logic              rst_meta_q, rst_sync_q;
  logic [NUM_CH-1:0] wr_hit;
  logic [CTRL_W-1:0] ctrl_v [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign wr_hit[g] = wr_en && (addr == ADDR_W'(g));
    clkdiv_channel u_ch (
      .clk       (clk),
      .rst_n     (rst_sync_q),
      .slow_tick (slow_tick),
      .fast_tick (fast_tick),
      .wr_hit    (wr_hit[g]),
      .wdata     (wdata),
      .ctrl_o    (ctrl_v[g]),
      .clk_out   (clk_out[g])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(i)) rdata = ctrl_v[i];
    end
  end

  // R8: a write reaches at most one channel
  a_r8_one_target: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $onehot0(wr_hit));
endmodule

// File: tb/clkout_divider_bank_tb_top.sv
module clkout_divider_bank_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_tick = 1'b0;
  logic       fast_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] clk_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit chk_req = 0;
  int tog [3] = '{0, 0, 0};
  logic [2:0] prev = '0;

  typedef struct { int ch; int start; int exp; string req; } item_t;
  item_t sb_q [$];

  always #5 clk = ~clk;

  clkout_divider_bank dut_i (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .clk_out(clk_out)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: counts output inversions, scores queued expectations
  always @(posedge clk) begin
    #2;
    for (int c = 0; c < 3; c++) begin
      if (clk_out[c] !== prev[c]) tog[c]++;
      prev[c] = clk_out[c];
    end
    if (chk_req) begin
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        chk(it.req, tog[it.ch] - it.start, it.exp);
      end
    end
  end

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(int nf, int ns);
    int n;
    n = (nf > ns) ? nf : ns;
    for (int i = 0; i < n; i++) begin
      fast_tick = (i < nf);
      slow_tick = (i < ns);
      @(negedge clk);
      fast_tick = 1'b0;
      slow_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic score();
    @(negedge clk); chk_req = 1'b1;
    @(negedge clk); chk_req = 1'b0;
  endtask

  task automatic window(int ch, logic [7:0] c, int nf, int ns, int exp, string req);
    item_t it;
    wr(ch, c);
    it.ch = ch; it.start = tog[ch]; it.exp = exp; it.req = req;
    ticks(nf, ns);
    sb_q.push_back(it);
    score();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9 reset state
    chk("R9 outputs", int'(clk_out), 0);
    for (int a = 0; a < 3; a++) begin
      addr = 2'(a); #1;
      chk("R9 ctrl byte", int'(rdata), 0);
    end

    // R8 readback and unused address
    wr(1, 8'h5A); wr(2, 8'hC3); wr(3, 8'hFF);
    addr = 2'd1; #1; chk("R8 readback ch1", int'(rdata), 'h5A);
    addr = 2'd2; #1; chk("R8 readback ch2", int'(rdata), 'hC3);
    addr = 2'd3; #1; chk("R8 unused addr reads 0", int'(rdata), 0);
    addr = 2'd0; #1; chk("R8 unused write leaves ch0", int'(rdata), 0);
    wr(1, 8'h00); wr(2, 8'h00);

    // R6 single tick inverts at once with both ratios 1
    wr(0, 8'h01);
    ticks(0, 1);
    chk("R6 first tick", int'(clk_out[0]), 1);
    window(0, 8'h01, 0, 10, 10, "R6 every tick");

    // R5 post exponent on slow source: 64 ticks / 8
    window(0, 8'h07, 0, 64, 8, "R5 post n=3");
    // R4 pre code ignored on slow source: code 7, n=1, 40 ticks -> 20
    window(0, 8'hE3, 0, 40, 20, "R4 slow bypass");

    // R3 every pre code on fast source, four periods each
    for (int c = 0; c < 8; c++) begin
      int d;
      d = (c == 7) ? 122 : (1 << c);
      window(0, 8'((c << 5) | 8'h11), 4 * d, 0, 4, $sformatf("R3 pre code %0d", c));
    end
    // R3 code 7 combined with n=2: 976 ticks -> 2
    window(0, 8'hF5, 976, 0, 2, "R3 code7 with post n=2");

    // R2 unselected source ignored
    window(0, 8'h11, 0, 50, 0, "R2 slow ignored when fast");
    window(0, 8'h01, 50, 0, 0, "R2 fast ignored when slow");

    // R1 disabled channel
    window(0, 8'h10, 20, 20, 0, "R1 disabled no toggles");
    chk("R1 disabled low", int'(clk_out[0]), 0);

    // R7 rewrite clears phase and output
    wr(0, 8'h51);
    ticks(3, 0);
    wr(0, 8'h51);
    ticks(1, 0);
    chk("R7 counter restarted", int'(clk_out[0]), 0);
    ticks(3, 0);
    chk("R7 new full period", int'(clk_out[0]), 1);
    wr(0, 8'h11);
    chk("R7 write drives low", int'(clk_out[0]), 0);

    // R8 independent channels together
    begin
      item_t a, b;
      wr(0, 8'h00);
      wr(1, 8'h31);
      wr(2, 8'h15);
      a.ch = 1; a.start = tog[1]; a.exp = 8; a.req = "R8 ch1 ratio 2";
      b.ch = 2; b.start = tog[2]; b.exp = 4; b.req = "R8 ch2 ratio 4";
      ticks(16, 0);
      sb_q.push_back(a);
      sb_q.push_back(b);
      score();
      chk("R8 ch0 idle", int'(clk_out[0]), 0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule